// File: doc/BRIEF.md
# Interrupt Pin Router And Vector Encoder

This block sits behind the source conditioning stage of an interrupt controller. It takes one pending bit per interrupt source and decides where each source lands: on one of six core interrupt pins, on the non-maskable line, and/or on the yield line, for every processor context named in that source's destination bitmap. Software programs the routing through a simple write port: a route word per source, a destination bitmap per source, and a control word per context.

Each context can run in pin mode or in vector mode. In pin mode the context sees six pin levels, and each level is the OR of every pending source routed to that pin and context. In vector mode the pin levels of that context are held low. The context instead receives a vector number, which is the highest active pin number plus one, or zero when no pin is active. The non-maskable and yield lines behave the same in both modes.

Top module: `irq_pin_router`

## Requirements
- R1: After reset all outputs are 0 and all routing state is cleared, so pending sources reach no output until routing is programmed.
- R2: A write to byte offset MAP_BASE + 4*n sets the route word of source n. Bit 31 enables pin routing and bits 5:0 choose the pin. While source n is pending, pin `tgt` of each context in its bitmap is high (core_pin_o bit c*NPIN+tgt).
- R3: The destination bitmap of source n lies at DST_BASE + 32*n. Context c is bit (c mod 32) of the word at byte offset 4*(c/32). Only contexts whose bit is set receive the source.
- R4: Route word bit 30 sends the source to nmi_o[c] and bit 29 sends it to yield_o[c], for every context c in its bitmap. Both are independent of bit 31 and of the pin field.
- R5: A pin level is the OR of all pending sources routed to it. It stays high while any one of them is pending and falls once none is.
- R6: A route word whose pin field is NPIN (6) or above drives no pin in any context.
- R7: Bit 0 of the control word at CTL_BASE + 4*c puts context c in vector mode. Its pins read 0 and vec_o[c*VW +: VW] equals the highest active pin plus 1, or 0 when none is active. In pin mode that vector field is 0.
- R8: A change of src_pend_i shows on the outputs after the next rising edge. A configuration write shows after the second rising edge following the write cycle.
- R9: A write to an address that matches no route, bitmap or control word changes nothing. This covers misaligned addresses, addresses past the last source, and bitmap words with no existing context.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_pend_i | input | NSRC | Pending bit per source |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | AW | Configuration byte address |
| cfg_wdata_i | input | 32 | Configuration write data |
| core_pin_o | output | NCTX*NPIN | Pin levels, context c pin p at bit c*NPIN+p |
| nmi_o | output | NCTX | Non-maskable line per context |
| yield_o | output | NCTX | Yield line per context |
| vec_o | output | NCTX*VW | Vector number per context in vector mode |

## Verification
Every output comes from a register. A pending change is therefore due one rising edge later, and a configuration write is due two edges later: one edge to store the value and one to register the output. The bench changes inputs on the falling edge and samples on a later falling edge, so each check falls in the cycle its result is due. The latency checks also sample before the due edge, to show the old value still holds. Vector results are checked at the boundaries pin 0 (vector 1), pin 5 (vector 6) and nothing pending (vector 0).

// File: rtl/router_pkg.sv
// Package: shared types for the interrupt pin router.
// Assumes a 32-bit configuration data path.
package router_pkg;
    localparam int CFG_DW = 32;
    localparam int PIN_EN_BIT = 31;  // route to a core pin
    localparam int NMI_EN_BIT = 30;  // route to the non-maskable line
    localparam int YLD_EN_BIT = 29;  // route to the yield line
    localparam int TGT_W = 6;        // pin select field, bits 5:0

    typedef struct packed {
        logic             pin_en;
        logic             nmi_en;
        logic             yld_en;
        logic [TGT_W-1:0] tgt;
    } route_map_t;

    // Pick the meaningful fields out of a raw route word.
    function automatic route_map_t decode_map(input logic [CFG_DW-1:0] w);
        route_map_t m;
        m.pin_en = w[PIN_EN_BIT];
        m.nmi_en = w[NMI_EN_BIT];
        m.yld_en = w[YLD_EN_BIT];
        m.tgt    = w[TGT_W-1:0];
        return m;
    endfunction
endpackage

// File: rtl/router_cfg.sv
// Module: router_cfg
// Holds the routing state: a route word per source, a destination
// bitmap per source and a mode bit per context. It decodes word-aligned
// byte addresses. Assumes the three address regions do not overlap.
module router_cfg
    import router_pkg::*;
#(
    parameter int NSRC     = 8,
    parameter int NCTX     = 4,
    parameter int AW       = 16,
    parameter int MAP_BASE = 'h0200,
    parameter int DST_BASE = 'h1000,
    parameter int CTL_BASE = 'h0080
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            we_i,
    input  logic [AW-1:0]                   addr_i,
    input  logic [CFG_DW-1:0]               wdata_i,
    output route_map_t [NSRC-1:0]           map_o,
    output logic [NCTX-1:0][NSRC-1:0]       dst_o,
    output logic [NCTX-1:0]                 vmode_o
);
    route_map_t [NSRC-1:0]     map_q;
    logic [NCTX-1:0][NSRC-1:0] dst_q;
    logic [NCTX-1:0]           vmode_q;

    // Route word store: one aligned word per source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_q <= '0;
        end else begin
            for (int s = 0; s < NSRC; s++) begin
                if (we_i && addr_i == AW'(MAP_BASE + 4 * s))
                    map_q[s] <= decode_map(wdata_i);
            end
        end
    end

    // Destination bitmap store: 32-byte stride per source, 32 contexts per word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dst_q <= '0;
        end else begin
            for (int s = 0; s < NSRC; s++) begin
                for (int c = 0; c < NCTX; c++) begin
                    if (we_i && addr_i == AW'(DST_BASE + 32 * s + 4 * (c / 32)))
                        dst_q[c][s] <= wdata_i[c % 32];
                end
            end
        end
    end

    // Context control store: bit 0 selects vector mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vmode_q <= '0;
        end else begin
            for (int c = 0; c < NCTX; c++) begin
                if (we_i && addr_i == AW'(CTL_BASE + 4 * c))
                    vmode_q[c] <= wdata_i[0];
            end
        end
    end

    assign map_o   = map_q;
    assign dst_o   = dst_q;
    assign vmode_o = vmode_q;

    // A write to source 0's route word lands with the written pin field.
    assert_map_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_i == AW'(MAP_BASE)) |=> map_q[0].tgt == $past(wdata_i[TGT_W-1:0]));

    // With no write strobe, no routing state moves.
    assert_state_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> ($stable(map_q) && $stable(dst_q) && $stable(vmode_q)));
endmodule

// File: rtl/router_vec_enc.sv
// Module: router_vec_enc
// Turns a pin level vector into a vector number: highest active pin
// plus one, or zero when no pin is active. Purely combinational.
module router_vec_enc #(
    parameter int NPIN = 6,
    parameter int VW   = $clog2(NPIN + 1)
) (
    input  logic [NPIN-1:0] lvl_i,
    output logic [VW-1:0]   vec_o
);
    // Ascending scan so that the highest active pin wins.
    always_comb begin
        vec_o = '0;
        for (int p = 0; p < NPIN; p++) begin
            if (lvl_i[p]) vec_o = VW'(p + 1);
        end
    end
endmodule

// File: rtl/router_ctx.sv
// Module: router_ctx
// Gathers, for one context, the pending sources whose bitmap names it,
// folds them onto pin, NMI and yield levels, and registers the result
// in either pin mode or vector mode. Pin fields of NPIN or above are dropped.
module router_ctx
    import router_pkg::*;
#(
    parameter int NSRC = 8,
    parameter int NPIN = 6,
    parameter int VW   = $clog2(NPIN + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NSRC-1:0]       pend_i,
    input  route_map_t [NSRC-1:0] map_i,
    input  logic [NSRC-1:0]       dest_i,
    input  logic                  vmode_i,
    output logic [NPIN-1:0]       pins_o,
    output logic                  nmi_o,
    output logic                  yield_o,
    output logic [VW-1:0]         vec_o
);
    logic [NPIN-1:0] lvl;
    logic            nmi_d;
    logic            yld_d;
    logic [VW-1:0]   vec_d;
    logic [NPIN-1:0] pins_q;
    logic            nmi_q;
    logic            yld_q;
    logic [VW-1:0]   vec_q;

    // OR every pending source aimed at this context onto its chosen lines.
    always_comb begin
        lvl   = '0;
        nmi_d = 1'b0;
        yld_d = 1'b0;
        for (int s = 0; s < NSRC; s++) begin
            if (pend_i[s] && dest_i[s]) begin
                if (map_i[s].nmi_en) nmi_d = 1'b1;
                if (map_i[s].yld_en) yld_d = 1'b1;
                if (map_i[s].pin_en) begin
                    for (int p = 0; p < NPIN; p++) begin
                        if (map_i[s].tgt == TGT_W'(p)) lvl[p] = 1'b1;
                    end
                end
            end
        end
    end

    router_vec_enc #(.NPIN(NPIN), .VW(VW)) u_enc (
        .lvl_i (lvl),
        .vec_o (vec_d)
    );

    // Output register: pins in pin mode, vector number in vector mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pins_q <= '0;
            nmi_q  <= 1'b0;
            yld_q  <= 1'b0;
            vec_q  <= '0;
        end else begin
            pins_q <= vmode_i ? '0 : lvl;
            vec_q  <= vmode_i ? vec_d : '0;
            nmi_q  <= nmi_d;
            yld_q  <= yld_d;
        end
    end

    assign pins_o  = pins_q;
    assign nmi_o   = nmi_q;
    assign yield_o = yld_q;
    assign vec_o   = vec_q;

    // Vector mode keeps the pin levels of this context low.
    assert_vmode_pins_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        vmode_i |=> pins_o == '0);

    // Pin mode never reports a vector number.
    assert_pinmode_vec_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !vmode_i |=> vec_o == '0);

    // A vector number never exceeds the pin count.
    assert_vec_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        vec_o <= VW'(NPIN));

    // Nothing pending for this context leaves every line low next cycle.
    assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_i & dest_i) == '0) |=> (pins_o == '0 && !nmi_o && !yield_o && vec_o == '0));
endmodule

// File: rtl/irq_pin_router.sv
// Module: irq_pin_router
// Top of the router: configuration store plus one routing slice per
// context. Outputs are flattened with context c occupying slice c.
// Assumes src_pend_i is already synchronous to clk.
module irq_pin_router
    import router_pkg::*;
#(
    parameter int NSRC     = 8,
    parameter int NCTX     = 4,
    parameter int NPIN     = 6,
    parameter int AW       = 16,
    parameter int MAP_BASE = 'h0200,
    parameter int DST_BASE = 'h1000,
    parameter int CTL_BASE = 'h0080,
    localparam int VW      = $clog2(NPIN + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NSRC-1:0]      src_pend_i,
    input  logic                 cfg_we_i,
    input  logic [AW-1:0]        cfg_addr_i,
    input  logic [CFG_DW-1:0]    cfg_wdata_i,
    output logic [NCTX*NPIN-1:0] core_pin_o,
    output logic [NCTX-1:0]      nmi_o,
    output logic [NCTX-1:0]      yield_o,
    output logic [NCTX*VW-1:0]   vec_o
);
    route_map_t [NSRC-1:0]     map_w;
    logic [NCTX-1:0][NSRC-1:0] dst_w;
    logic [NCTX-1:0]           vmode_w;
    logic [NCTX-1:0][NPIN-1:0] pins_w;
    logic [NCTX-1:0][VW-1:0]   vec_w;

    router_cfg #(
        .NSRC(NSRC), .NCTX(NCTX), .AW(AW),
        .MAP_BASE(MAP_BASE), .DST_BASE(DST_BASE), .CTL_BASE(CTL_BASE)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we_i),
        .addr_i  (cfg_addr_i),
        .wdata_i (cfg_wdata_i),
        .map_o   (map_w),
        .dst_o   (dst_w),
        .vmode_o (vmode_w)
    );

    for (genvar c = 0; c < NCTX; c++) begin : g_ctx
        router_ctx #(.NSRC(NSRC), .NPIN(NPIN), .VW(VW)) u_ctx (
            .clk     (clk),
            .rst_n   (rst_n),
            .pend_i  (src_pend_i),
            .map_i   (map_w),
            .dest_i  (dst_w[c]),
            .vmode_i (vmode_w[c]),
            .pins_o  (pins_w[c]),
            .nmi_o   (nmi_o[c]),
            .yield_o (yield_o[c]),
            .vec_o   (vec_w[c])
        );
    end

    assign core_pin_o = pins_w;
    assign vec_o      = vec_w;
endmodule

// File: tb/irq_pin_router_test.sv
module irq_pin_router_test;
    localparam int NSRC = 8;
    localparam int NCTX = 4;
    localparam int NPIN = 6;
    localparam int AW   = 16;
    localparam int VW   = 3;
    localparam int MAPB = 'h0200;
    localparam int DSTB = 'h1000;
    localparam int CTLB = 'h0080;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [NSRC-1:0]      pend = '0;
    logic                 we = 1'b0;
    logic [AW-1:0]        addr = '0;
    logic [31:0]          wdata = '0;
    logic [NCTX*NPIN-1:0] pins;
    logic [NCTX-1:0]      nmi;
    logic [NCTX-1:0]      yld;
    logic [NCTX*VW-1:0]   vec;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    irq_pin_router #(
        .NSRC(NSRC), .NCTX(NCTX), .NPIN(NPIN), .AW(AW),
        .MAP_BASE(MAPB), .DST_BASE(DSTB), .CTL_BASE(CTLB)
    ) uut (
        .clk(clk), .rst_n(rst_n), .src_pend_i(pend),
        .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata),
        .core_pin_o(pins), .nmi_o(nmi), .yield_o(yld), .vec_o(vec)
    );

    function automatic logic [63:0] pb(input int c, input int p);
        return 64'(1) << (c * NPIN + p);
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Write ends on the falling edge after the storing edge.
    task automatic wr(input int a, input logic [31:0] d);
        addr = AW'(a);
        wdata = d;
        we = 1'b1;
        step();
        we = 1'b0;
    endtask

    task automatic wr_settle(input int a, input logic [31:0] d);
        wr(a, d);
        step();
    endtask

    task automatic drive(input logic [NSRC-1:0] p);
        pend = p;
        step();
    endtask

    task automatic t_reset();
        check("R1 pins", 64'(pins), 0);
        check("R1 nmi/yield/vec", 64'({nmi, yld, vec}), 0);
        drive('1);
        check("R1 unprogrammed pins", 64'(pins), 0);
        check("R1 unprogrammed nmi/yield", 64'({nmi, yld}), 0);
        drive('0);
    endtask

    task automatic t_basic();
        wr(MAPB + 0, 32'h8000_0002);
        wr_settle(DSTB + 0, 32'h2);
        pend = 8'h01;
        check("R8 before edge", 64'(pins), 0);
        step();
        check("R2 src0 pin2 ctx1", 64'(pins), pb(1, 2));
        drive(8'h00);
        check("R8 drop next edge", 64'(pins), 0);
    endtask

    task automatic t_multicast();
        wr(MAPB + 4, 32'h8000_0005);
        wr_settle(DSTB + 32, 32'h9);
        drive(8'h02);
        check("R3 ctx0 and ctx3 only", 64'(pins), pb(0, 5) | pb(3, 5));
        drive(8'h00);
    endtask

    task automatic t_or();
        wr(MAPB + 8, 32'h8000_0002);
        wr_settle(DSTB + 64, 32'h2);
        drive(8'h05);
        check("R5 two sources one pin", 64'(pins), pb(1, 2));
        drive(8'h04);
        check("R5 one remaining", 64'(pins), pb(1, 2));
        drive(8'h07);
        check("R5 mixed pins", 64'(pins), pb(1, 2) | pb(0, 5) | pb(3, 5));
        drive(8'h00);
        check("R5 all dropped", 64'(pins), 0);
    endtask

    task automatic t_nmi_yield();
        wr(MAPB + 12, 32'h4000_0001);
        wr(DSTB + 96, 32'h5);
        wr(MAPB + 16, 32'h2000_0000);
        wr(DSTB + 128, 32'h4);
        wr(MAPB + 24, 32'hE000_0003);
        wr_settle(DSTB + 192, 32'h1);
        drive(8'h08);
        check("R4 nmi only", 64'({pins, nmi, yld}), 64'({24'h0, 4'h5, 4'h0}));
        drive(8'h10);
        check("R4 yield only", 64'({pins, nmi, yld}), 64'({24'h0, 4'h0, 4'h4}));
        drive(8'h40);
        check("R4 pin nmi yield together", 64'({pins, nmi, yld}),
              (pb(0, 3) << 8) | 64'h11);
        drive(8'h00);
    endtask

    task automatic t_reserved();
        wr(MAPB + 20, 32'h8000_0006);
        wr_settle(DSTB + 160, 32'hF);
        drive(8'h20);
        check("R6 pin field 6", 64'({pins, nmi, yld}), 0);
        wr_settle(MAPB + 20, 32'h8000_003F);
        check("R6 pin field 63", 64'({pins, nmi, yld}), 0);
        drive(8'h00);
    endtask

    task automatic t_ignored();
        wr(MAPB + 1, 32'h0);
        wr(MAPB + 4 * NSRC, 32'h0);
        wr(DSTB + 4, 32'hFFFF_FFFF);
        wr_settle(CTLB + 4 * NCTX, 32'h1);
        drive(8'h01);
        check("R9 stray writes no effect", 64'({pins, vec}), 64'({pb(1, 2)[23:0], 12'h0}));
        drive(8'h00);
    endtask

    task automatic t_vector();
        pend = 8'h01;
        step();
        wr(CTLB + 4, 32'h1);
        check("R8 mode write not yet visible", 64'(pins), pb(1, 2));
        step();
        check("R7 pins low in vector mode", 64'(pins), 0);
        check("R7 pin2 gives vector 3", 64'(vec), 64'(3) << VW);
        wr_settle(DSTB + 32, 32'hB);
        drive(8'h03);
        check("R7 highest pin 5 gives 6", 64'(vec), 64'(6) << VW);
        check("R7 other contexts keep pins", 64'(pins), pb(0, 5) | pb(3, 5));
        wr_settle(MAPB + 28, 32'h8000_0000);
        wr_settle(DSTB + 224, 32'h2);
        drive(8'h80);
        check("R7 pin0 gives vector 1", 64'(vec), 64'(1) << VW);
        drive(8'h00);
        check("R7 nothing pending gives 0", 64'(vec), 0);
        wr_settle(CTLB + 4, 32'hFFFF_FFFE);
        drive(8'h01);
        check("R7 back to pin mode", 64'({pins, vec}), 64'({pb(1, 2)[23:0], 12'h0}));
        drive(8'h00);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        step();
        t_reset();
        t_basic();
        t_multicast();
        t_or();
        t_nmi_yield();
        t_reserved();
        t_ignored();
        t_vector();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule